// File: doc/BRIEF.md
# Lockable Prescaler Control Register

This block holds the configuration for a clock prescaler that turns the bus clock into a timing tick of about 1 MHz. Nonvolatile-memory program and erase sequences use that tick to time their steps. The configuration is one 8-bit register on a simple bus port: a select, a write enable, write data and read data. The register carries:

- a divider field in the low bits;
- a lock bit above the divider;
- a read-only "loaded" flag in the top bit.

Software picks a divider so that the bus clock divided by (divider + 1) lands near 1 MHz. It can then set the lock, which freezes the divider until reset while the part runs in normal mode. A special-mode input lifts the lock, so that test or debug code can rewrite the divider and the lock bit as often as needed. A command-busy input marks a memory command in progress. The register refuses every write during that time, so the timing base never shifts under a running algorithm.

The tick generator stays silent until the register has been written once. After that it gives a one-cycle pulse every (divider + 1) bus clocks. A new divider value is picked up only when the counter next reloads, so the period in progress always finishes at full length.

Top module: `tick_prescale_ctl`

## Requirements
- R1: After reset, rd_data reads 0x00 and tick is low.
- R2: Bit 7 of rd_data (loaded flag) reads 0 until the first accepted write after reset, then reads 1 until reset; writing 0 to bit 7 never clears it.
- R3: In normal mode (special_mode=0), writing 1 to bit 6 (lock) sets it, and a later write of 0 to bit 6 leaves it at 1.
- R4: In normal mode, a write updates bits 5..0 (divider) only if the lock read 0 before that write; a write that sets the lock still loads the divider it carries.
- R5: In special mode (special_mode=1), every accepted write loads bits 6..0 from wr_data[6:0], so the lock can be cleared and the divider changed whatever the lock state.
- R6: A write presented while cmd_busy=1 is dropped completely: the divider, the lock and the loaded flag all stay unchanged.
- R7: A write takes effect only when sel=1 and wr_en=1 in the same cycle.
- R8: tick stays low while the loaded flag is 0; the first tick is high in the cycle right after the loading write.
- R9: Once loaded, tick is a one-cycle pulse repeating every (divider + 1) clock cycles.
- R10: A divider written in the same cycle as a counter reload does not affect the interval in progress; the following interval uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data: [7] ignored, [6] lock, [5:0] divider |
| special_mode | input | 1 | 1 = special mode, lock is overridden |
| cmd_busy | input | 1 | 1 = memory command running, writes refused |
| rd_data | output | 8 | Register contents: [7] loaded, [6] lock, [5:0] divider |
| tick | output | 1 | Timing tick pulse |

## Verification
A register write and a counter reload can land on the same clock edge. At that edge the reload must take the old divider while the register takes the new one. The bench provokes this by waiting for a sampled tick and presenting a divider write in that same cycle. It then judges the result by counting the cycles to each of the next two ticks: the first interval must follow the old divider and the second the new one. The bench also drives a write in the same cycle as cmd_busy and requires that the register reads back unchanged.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

   // Kind of register update resolved from the bus-side controls.
   typedef enum logic [1:0] {
      WR_NONE    = 2'd0,
      WR_NORMAL  = 2'd1,
      WR_SPECIAL = 2'd2
   } wr_kind_e;

   localparam int DIV_W_MIN = 1;
   localparam int DIV_W_MAX = 16;

endpackage

// File: rtl/pscl_cfg_regs.sv
module pscl_cfg_regs
   import pscl_pkg::*;
#(
   parameter int DIV_W = 6,
   localparam int REG_W = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             special_mode,
   input  logic             cmd_busy,
   output logic             loaded,
   output logic             lock,
   output logic [DIV_W-1:0] div
);

   wr_kind_e kind;

   // The busy input masks the whole write, including the loaded flag.
   always_comb begin
      if (!(sel && wr_en) || cmd_busy) kind = WR_NONE;
      else if (special_mode)           kind = WR_SPECIAL;
      else                             kind = WR_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded <= 1'b0;
         lock   <= 1'b0;
         div    <= '0;
      end else begin
         case (kind)
            WR_NORMAL: begin
               loaded <= 1'b1;
               lock   <= lock | wr_data[DIV_W];
               if (!lock) div <= wr_data[DIV_W-1:0];
            end
            WR_SPECIAL: begin
               loaded <= 1'b1;
               lock   <= wr_data[DIV_W];
               div    <= wr_data[DIV_W-1:0];
            end
            default: ;
         endcase
      end
   end

   // Bit REG_W-1 of the write data never reaches a register.
   logic unused_top;
   assign unused_top = wr_data[REG_W-1];

endmodule

// File: rtl/pscl_tick_gen.sv
module pscl_tick_gen #(
   parameter int DIV_W    = 6,
   parameter bit REG_TICK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             expire;

   assign expire = run && (cnt == '0);

   // The divider is sampled only at reload, so a period in progress is never cut short.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (expire) cnt <= div;
      else             cnt <= cnt - 1'b1;
   end

   generate
      if (REG_TICK) begin : g_reg_tick
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= expire;
         end
         assign tick = tick_q;
      end else begin : g_comb_tick
         assign tick = expire;
      end
   endgenerate

endmodule

// File: rtl/tick_prescale_ctl.sv
module tick_prescale_ctl
   import pscl_pkg::*;
#(
   parameter int DIV_W    = 6,
   parameter bit REG_TICK = 1'b0,
   localparam int REG_W   = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             special_mode,
   input  logic             cmd_busy,
   output logic [REG_W-1:0] rd_data,
   output logic             tick
);

   generate
      if (DIV_W < DIV_W_MIN || DIV_W > DIV_W_MAX) begin : g_bad_width
         $error("tick_prescale_ctl: DIV_W out of supported range");
      end
   endgenerate

   logic             loaded;
   logic             lock;
   logic [DIV_W-1:0] div;

   pscl_cfg_regs #(.DIV_W(DIV_W)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel          (sel),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .special_mode (special_mode),
      .cmd_busy     (cmd_busy),
      .loaded       (loaded),
      .lock         (lock),
      .div          (div)
   );

   pscl_tick_gen #(.DIV_W(DIV_W), .REG_TICK(REG_TICK)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (loaded),
      .div   (div),
      .tick  (tick)
   );

   assign rd_data = {loaded, lock, div};

endmodule

// File: rtl/pscl_chk.sv
module pscl_chk #(
   parameter int DIV_W  = 6,
   localparam int REG_W = DIV_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             wr_en,
   input logic             special_mode,
   input logic             cmd_busy,
   input logic [REG_W-1:0] rd_data,
   input logic             tick
);

   assert_busy_drops_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_en && cmd_busy) |=> $stable(rd_data));

   assert_no_write_without_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel && wr_en) |=> $stable(rd_data));

   assert_loaded_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1] |=> rd_data[REG_W-1]);

   assert_lock_sticky_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && rd_data[DIV_W]) |=> rd_data[DIV_W]);

   assert_locked_div_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && rd_data[DIV_W]) |=> $stable(rd_data[DIV_W-1:0]));

   assert_silent_until_loaded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[REG_W-1] |-> !tick);

endmodule

bind tick_prescale_ctl pscl_chk #(.DIV_W(DIV_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sel          (sel),
   .wr_en        (wr_en),
   .special_mode (special_mode),
   .cmd_busy     (cmd_busy),
   .rd_data      (rd_data),
   .tick         (tick)
);

// File: tb/tb_tick_prescale_ctl.sv
`timescale 1ns/1ps
module tb_tick_prescale_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       special_mode = 1'b0;
   logic       cmd_busy = 1'b0;
   logic [7:0] rd_data;
   logic       tick;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tick_prescale_ctl dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
      .special_mode(special_mode), .cmd_busy(cmd_busy), .rd_data(rd_data), .tick(tick)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; cmd_busy = 1'b0; special_mode = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Presents a write for one edge; returns at the negedge after it.
   task automatic do_write(input logic [7:0] d, input logic s = 1'b1, input logic w = 1'b1);
      @(negedge clk);
      sel = s; wr_en = w; wr_data = d;
      @(negedge clk);
      sel = 1'b0; wr_en = 1'b0;
   endtask

   // Counts negedges until tick is sampled high.
   task automatic cycles_to_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick && n < 200);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1 rd_data after reset", rd_data, 8'h00);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (tick) begin check("R8 tick before load", tick, 0); break; end
      end
      check("R1 tick after reset", tick, 0);
   endtask

   task automatic t_busy_and_strobe();
      do_reset();
      cmd_busy = 1'b1;
      do_write(8'h45);
      cmd_busy = 1'b0;
      check("R6 write during busy dropped", rd_data, 8'h00);
      do_write(8'h45, 1'b0, 1'b1);
      check("R7 write without sel", rd_data, 8'h00);
      do_write(8'h45, 1'b1, 1'b0);
      check("R7 select without wr_en", rd_data, 8'h00);
      check("R8 no tick while unloaded", tick, 0);
   endtask

   task automatic t_loaded_flag();
      do_reset();
      do_write(8'h00);
      check("R2 loaded after write of zero", rd_data, 8'h80);
      do_write(8'h05);
      check("R2 bit7 not cleared by write", rd_data, 8'h85);
      cmd_busy = 1'b1;
      do_write(8'h3A);
      cmd_busy = 1'b0;
      check("R6 busy write keeps value", rd_data, 8'h85);
   endtask

   task automatic t_lock_normal();
      do_reset();
      do_write(8'h47);
      check("R4 lock-setting write loads divider", rd_data, 8'hC7);
      do_write(8'h12);
      check("R3 R4 locked register unchanged", rd_data, 8'hC7);
      do_write(8'h7F);
      check("R4 locked divider ignored", rd_data, 8'hC7);
   endtask

   task automatic t_special();
      do_reset();
      special_mode = 1'b1;
      do_write(8'h47);
      check("R5 special write", rd_data, 8'hC7);
      do_write(8'h12);
      check("R5 special clears lock and rewrites divider", rd_data, 8'h92);
      special_mode = 1'b0;
      do_write(8'h05);
      check("R4 unlocked normal write", rd_data, 8'h85);
   endtask

   task automatic t_tick_period();
      int n;
      do_reset();
      do_write(8'h03);
      check("R8 first tick right after load", tick, 1);
      cycles_to_tick(n);
      check("R9 period div=3", n, 4);
      cycles_to_tick(n);
      check("R9 period div=3 repeat", n, 4);
      do_write(8'h05);
      cycles_to_tick(n);
      cycles_to_tick(n);
      check("R9 period div=5", n, 6);
      @(negedge clk);
      check("R9 tick lasts one cycle", tick, 0);
   endtask

   task automatic t_retune();
      int n;
      do_reset();
      do_write(8'h09);
      cycles_to_tick(n);
      // tick is high now: present the new divider on the reload edge
      sel = 1'b1; wr_en = 1'b1; wr_data = 8'h02;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin sel = 1'b0; wr_en = 1'b0; end
      end while (!tick && n < 200);
      check("R10 interval keeps old divider", n, 10);
      cycles_to_tick(n);
      check("R10 next interval uses new divider", n, 3);
      check("R10 register holds new divider", rd_data, 8'h82);
   endtask

   initial begin
      t_reset();
      t_busy_and_strobe();
      t_loaded_flag();
      t_lock_normal();
      t_special();
      t_tick_period();
      t_retune();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule